// File: doc/BRIEF.md
# CPU Trap Arbitration and Vectoring Unit

This block decides which exception the processor enters next and carries out the entry. It has three kinds of request. The first is a software trap issued by an instruction, with a 7-bit trap number. The second is a group of hardware fault sources that all share one class vector. The third is a single pre-prioritised maskable interrupt request that carries its own trap number and priority level. When the unit is idle it picks one winner. It then saves the status word, the code segment pointer (when segmentation is on) and the instruction pointer to the system stack, one word per accepted handshake. After that it pulses a completion strobe together with the target vector, the new code segment and the new CPU priority level.

Each fault source sets its own sticky flag, and software clears a flag by writing zero to its bit. Any fault arrival also leaves a pending request for the shared class vector, so a repeat fault is serviced again even when its flag was never cleared. A per-source cancel input stops the writeback of the instruction that faulted. A hardware entry raises the priority level to the maximum. While the status word holds that level, further fault entries wait.

Top module: `trap_dispatch`

## Requirements
- R1: On the completion pulse, `vec_o` equals the selected trap number times four (trap numbers 0x00 to 0x7F give vectors 0x000 to 0x1FC).
- R2: After acceptance the unit pushes the status word, then the code segment pointer zero-extended (only when `seg_en_i` was 1 at acceptance), then the instruction pointer. Each word is held stable on `stk_data_o` with `stk_valid_o` high until `stk_ready_i` is seen.
- R3: On the completion pulse, `csp_o` is 0 when segmentation was enabled at acceptance. Otherwise it is the code segment pointer captured at acceptance.
- R4: A software trap is acknowledged on `sw_ack_o`, never pulses `irq_ack_o`, and completes with `level_o` equal to the current level in status word bits [15:12].
- R5: `flags_o` bit i is set one cycle after `fault_i[i]` is high. It is cleared only by a cycle with `flag_clr_we_i` high and `flag_clr_data_i[i]` low. A fault in the same cycle wins over the clear.
- R6: A hardware entry completes with trap number 0x0A (vector 0x028) and level 15. `cause_o` then gives the lowest bit index among the faults pending at acceptance, and bit 0 has the highest priority.
- R7: When idle, a pending hardware fault wins over a software trap, and a software trap wins over an interrupt. A request that loses in that cycle is dropped. `src_o` reports the winner: 1 hardware, 2 software, 3 interrupt.
- R8: While status word bits [15:12] equal 15, no hardware entry is taken. The pending request is serviced once the level drops.
- R9: An interrupt is accepted only when `irq_lvl_i` is above the current level and `irq_num_i` is outside the reserved range 0x0B to 0x0F. Acceptance pulses `irq_ack_o`, and the entry completes with `level_o` equal to `irq_lvl_i`.
- R10: `wb_en_o` is high exactly when `commit_i` is high and no source has both `fault_i` and `cancel_i` high.
- R11: A fault that arrives while its flag is already set, or while an entry is in progress, causes one more hardware entry.
- R12: `busy_o` is high from the cycle after acceptance until the completion pulse. `done_o` is a one-cycle pulse in the cycle after the final stack handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_i | input | 6 | Fault conditions, one bit per source |
| cancel_i | input | 6 | Per-source cancel of the faulting instruction |
| commit_i | input | 1 | Instruction would write back this cycle |
| flag_clr_we_i | input | 1 | Write strobe for the flag clear |
| flag_clr_data_i | input | 6 | Zero bits clear the matching flags |
| sw_req_i | input | 1 | Software trap request |
| sw_num_i | input | 7 | Software trap number |
| irq_req_i | input | 1 | Prioritised interrupt request |
| irq_num_i | input | 7 | Interrupt trap number |
| irq_lvl_i | input | 4 | Interrupt priority level |
| psw_i | input | 16 | Current status word, level in bits [15:12] |
| csp_i | input | 8 | Current code segment pointer |
| ip_i | input | 16 | Current instruction pointer |
| seg_en_i | input | 1 | Segmentation enabled |
| stk_ready_i | input | 1 | Stack accepts the word |
| stk_valid_o | output | 1 | Stack word valid |
| stk_data_o | output | 16 | Stack word |
| sw_ack_o | output | 1 | Software trap accepted |
| irq_ack_o | output | 1 | Interrupt accepted |
| busy_o | output | 1 | Entry in progress |
| done_o | output | 1 | Jump pulse |
| vec_o | output | 9 | Target vector address |
| level_o | output | 4 | New CPU priority level |
| csp_o | output | 8 | New code segment pointer |
| src_o | output | 2 | Winning source code |
| cause_o | output | 3 | Index of the serviced fault |
| flags_o | output | 6 | Sticky fault flags |
| wb_en_o | output | 1 | Writeback enable |

## Verification
Software traps are tried at the lowest, a middle and the top trap number, with segmentation both on and off and with a stack that stalls on alternate cycles. This separates the vector arithmetic from the word count and the hold behaviour of the push. Interrupts are offered above, below and inside the reserved number range. Faults arrive several at a time, together with a software request, while the level is at its maximum, and again while their own flags are still set. This tells priority order, fault-cause encoding, level blocking and re-request apart. Flag clears are issued both alone and in the same cycle as a fault on the same bit.

// File: rtl/trap_pkg.sv
package trap_pkg;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_HW   = 2'd1,
    SRC_SW   = 2'd2,
    SRC_IRQ  = 2'd3
  } trap_src_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PUSH = 2'd1,
    ST_JUMP = 2'd2
  } entry_st_e;

  typedef enum logic [1:0] {
    W_PSW = 2'd0,
    W_CSP = 2'd1,
    W_IP  = 2'd2
  } stack_word_e;

  localparam int unsigned CLASSB_NUM = 10;
  localparam int unsigned RSV_LO     = 11;
  localparam int unsigned RSV_HI     = 15;

  // Vector address of a trap number: four bytes per slot.
  function automatic logic [31:0] vector_of(input logic [31:0] num);
    return num << 2;
  endfunction

  // Numbers that arbitration must never hand out.
  function automatic logic is_reserved(input logic [31:0] num);
    return (num >= RSV_LO) && (num <= RSV_HI);
  endfunction

endpackage

// File: rtl/trap_flag_bank.sv
module trap_flag_bank #(
  parameter int NF = 6,
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] fault_i,
  input  logic          clr_we_i,
  input  logic [NF-1:0] clr_data_i,
  input  logic          take_i,
  output logic [NF-1:0] flags_o,
  output logic          pend_o,
  output logic [CW-1:0] cause_o
);

  logic [NF-1:0] flag_q;
  logic [NF-1:0] arr_q;
  logic [NF-1:0] keep_mask;

  assign keep_mask = clr_we_i ? clr_data_i : {NF{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      arr_q  <= '0;
    end else begin
      flag_q <= (flag_q & keep_mask) | fault_i;
      arr_q  <= take_i ? fault_i : (arr_q | fault_i);
    end
  end

  // Lowest index among pending arrivals wins.
  always_comb begin
    cause_o = '0;
    for (int i = NF - 1; i >= 0; i--) begin
      if (arr_q[i]) cause_o = CW'(i);
    end
  end

  assign flags_o = flag_q;
  assign pend_o  = |arr_q;

endmodule

// File: rtl/trap_select.sv
module trap_select
  import trap_pkg::*;
#(
  parameter int TW = 7,
  parameter int LW = 4
) (
  input  logic          idle_i,
  input  logic          hw_pend_i,
  input  logic [LW-1:0] cur_lvl_i,
  input  logic          sw_req_i,
  input  logic [TW-1:0] sw_num_i,
  input  logic          irq_req_i,
  input  logic [TW-1:0] irq_num_i,
  input  logic [LW-1:0] irq_lvl_i,
  output trap_src_e     src_o,
  output logic [TW-1:0] num_o,
  output logic [LW-1:0] lvl_o
);

  localparam logic [LW-1:0] LVL_MAX = {LW{1'b1}};

  logic hw_ok;
  logic irq_ok;

  assign hw_ok  = hw_pend_i && (cur_lvl_i != LVL_MAX);
  assign irq_ok = irq_req_i && (irq_lvl_i > cur_lvl_i) && !is_reserved(32'(irq_num_i));

  always_comb begin
    src_o = SRC_NONE;
    num_o = irq_num_i;
    lvl_o = cur_lvl_i;
    if (idle_i) begin
      if (hw_ok) begin
        src_o = SRC_HW;
        num_o = TW'(CLASSB_NUM);
        lvl_o = LVL_MAX;
      end else if (sw_req_i) begin
        src_o = SRC_SW;
        num_o = sw_num_i;
        lvl_o = cur_lvl_i;
      end else if (irq_ok) begin
        src_o = SRC_IRQ;
        num_o = irq_num_i;
        lvl_o = irq_lvl_i;
      end
    end
  end

endmodule

// File: rtl/trap_push_seq.sv
module trap_push_seq
  import trap_pkg::*;
#(
  parameter int TW   = 7,
  parameter int LW   = 4,
  parameter int WW   = 16,
  parameter int SEGW = 8,
  parameter int CW   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  trap_src_e       src_i,
  input  logic [TW-1:0]   num_i,
  input  logic [LW-1:0]   lvl_i,
  input  logic [CW-1:0]   cause_i,
  input  logic            seg_en_i,
  input  logic [WW-1:0]   psw_i,
  input  logic [WW-1:0]   ip_i,
  input  logic [SEGW-1:0] csp_i,
  input  logic            stk_ready_i,
  output logic            idle_o,
  output logic            stk_valid_o,
  output logic [WW-1:0]   stk_data_o,
  output logic            done_o,
  output logic [TW+1:0]   vec_o,
  output logic [LW-1:0]   lvl_o,
  output logic [SEGW-1:0] csp_o,
  output logic [CW-1:0]   cause_o,
  output trap_src_e       src_o
);

  localparam int VW = TW + 2;

  entry_st_e     st_q;
  stack_word_e   wsel_q;
  logic [WW-1:0] psw_q;
  logic [WW-1:0] ip_q;
  logic [SEGW-1:0] csp_q;
  logic          seg_q;
  logic [VW-1:0] vec_q;
  logic [LW-1:0] lvl_q;
  logic [CW-1:0] cause_q;
  trap_src_e     src_q;
  logic          start;
  logic          stack_hs;

  assign start    = (st_q == ST_IDLE) && (src_i != SRC_NONE);
  assign stack_hs = stk_valid_o && stk_ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      wsel_q  <= W_PSW;
      psw_q   <= '0;
      ip_q    <= '0;
      csp_q   <= '0;
      seg_q   <= 1'b0;
      vec_q   <= '0;
      lvl_q   <= '0;
      cause_q <= '0;
      src_q   <= SRC_NONE;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (start) begin
            st_q    <= ST_PUSH;
            wsel_q  <= W_PSW;
            psw_q   <= psw_i;
            ip_q    <= ip_i;
            csp_q   <= csp_i;
            seg_q   <= seg_en_i;
            vec_q   <= VW'(vector_of(32'(num_i)));
            lvl_q   <= lvl_i;
            cause_q <= (src_i == SRC_HW) ? cause_i : '0;
            src_q   <= src_i;
          end
        end
        ST_PUSH: begin
          if (stack_hs) begin
            if (wsel_q == W_IP) begin
              st_q <= ST_JUMP;
            end else if ((wsel_q == W_PSW) && seg_q) begin
              wsel_q <= W_CSP;
            end else begin
              wsel_q <= W_IP;
            end
          end
        end
        ST_JUMP: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (wsel_q)
      W_PSW:   stk_data_o = psw_q;
      W_CSP:   stk_data_o = WW'(csp_q);
      default: stk_data_o = ip_q;
    endcase
  end

  assign idle_o      = (st_q == ST_IDLE);
  assign stk_valid_o = (st_q == ST_PUSH);
  assign done_o      = (st_q == ST_JUMP);
  assign vec_o       = vec_q;
  assign lvl_o       = lvl_q;
  assign csp_o       = seg_q ? '0 : csp_q;
  assign cause_o     = cause_q;
  assign src_o       = src_q;

endmodule

// File: rtl/trap_dispatch.sv
module trap_dispatch
  import trap_pkg::*;
#(
  parameter int NF   = 6,
  parameter int TW   = 7,
  parameter int LW   = 4,
  parameter int WW   = 16,
  parameter int SEGW = 8,
  parameter int CW   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NF-1:0]   fault_i,
  input  logic [NF-1:0]   cancel_i,
  input  logic            commit_i,
  input  logic            flag_clr_we_i,
  input  logic [NF-1:0]   flag_clr_data_i,
  input  logic            sw_req_i,
  input  logic [TW-1:0]   sw_num_i,
  input  logic            irq_req_i,
  input  logic [TW-1:0]   irq_num_i,
  input  logic [LW-1:0]   irq_lvl_i,
  input  logic [WW-1:0]   psw_i,
  input  logic [SEGW-1:0] csp_i,
  input  logic [WW-1:0]   ip_i,
  input  logic            seg_en_i,
  input  logic            stk_ready_i,
  output logic            stk_valid_o,
  output logic [WW-1:0]   stk_data_o,
  output logic            sw_ack_o,
  output logic            irq_ack_o,
  output logic            busy_o,
  output logic            done_o,
  output logic [TW+1:0]   vec_o,
  output logic [LW-1:0]   level_o,
  output logic [SEGW-1:0] csp_o,
  output logic [1:0]      src_o,
  output logic [CW-1:0]   cause_o,
  output logic [NF-1:0]   flags_o,
  output logic            wb_en_o
);

  logic [LW-1:0] cur_lvl;
  logic          idle;
  logic          hw_pend;
  logic [CW-1:0] pend_cause;
  trap_src_e     sel_src;
  logic [TW-1:0] sel_num;
  logic [LW-1:0] sel_lvl;
  logic          hw_take;
  trap_src_e     seq_src;

  assign cur_lvl = psw_i[WW-1 -: LW];
  assign hw_take = (sel_src == SRC_HW);

  trap_flag_bank #(.NF(NF), .CW(CW)) u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .fault_i    (fault_i),
    .clr_we_i   (flag_clr_we_i),
    .clr_data_i (flag_clr_data_i),
    .take_i     (hw_take),
    .flags_o    (flags_o),
    .pend_o     (hw_pend),
    .cause_o    (pend_cause)
  );

  trap_select #(.TW(TW), .LW(LW)) u_select (
    .idle_i    (idle),
    .hw_pend_i (hw_pend),
    .cur_lvl_i (cur_lvl),
    .sw_req_i  (sw_req_i),
    .sw_num_i  (sw_num_i),
    .irq_req_i (irq_req_i),
    .irq_num_i (irq_num_i),
    .irq_lvl_i (irq_lvl_i),
    .src_o     (sel_src),
    .num_o     (sel_num),
    .lvl_o     (sel_lvl)
  );

  trap_push_seq #(.TW(TW), .LW(LW), .WW(WW), .SEGW(SEGW), .CW(CW)) u_push (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_i       (sel_src),
    .num_i       (sel_num),
    .lvl_i       (sel_lvl),
    .cause_i     (pend_cause),
    .seg_en_i    (seg_en_i),
    .psw_i       (psw_i),
    .ip_i        (ip_i),
    .csp_i       (csp_i),
    .stk_ready_i (stk_ready_i),
    .idle_o      (idle),
    .stk_valid_o (stk_valid_o),
    .stk_data_o  (stk_data_o),
    .done_o      (done_o),
    .vec_o       (vec_o),
    .lvl_o       (level_o),
    .csp_o       (csp_o),
    .cause_o     (cause_o),
    .src_o       (seq_src)
  );

  assign src_o     = seq_src;
  assign busy_o    = !idle;
  assign sw_ack_o  = (sel_src == SRC_SW);
  assign irq_ack_o = (sel_src == SRC_IRQ);
  assign wb_en_o   = commit_i && !(|(fault_i & cancel_i));

endmodule

// File: rtl/trap_dispatch_checker.sv
module trap_dispatch_checker #(
  parameter int NF = 6,
  parameter int TW = 7,
  parameter int LW = 4,
  parameter int WW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          stk_valid,
  input logic          stk_ready,
  input logic [WW-1:0] stk_data,
  input logic          done,
  input logic [1:0]    src,
  input logic [TW+1:0] vec,
  input logic [LW-1:0] level,
  input logic          sw_ack,
  input logic          irq_ack,
  input logic [TW-1:0] irq_num,
  input logic [NF-1:0] flags,
  input logic          clr_we,
  input logic          hw_take,
  input logic [LW-1:0] cur_lvl
);

  AST_STACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_valid && !stk_ready) |=> (stk_valid && $stable(stk_data))); // R2

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R12

  AST_DONE_AFTER_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(stk_valid && stk_ready)); // R12

  AST_CLASSB_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (src == 2'd1)) |-> ((vec == (TW+2)'(40)) && (level == {LW{1'b1}}))); // R6

  AST_SW_NOT_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    sw_ack |-> !irq_ack); // R4

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we |=> ((flags & $past(flags)) == $past(flags))); // R5

  AST_LEVEL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    hw_take |-> (cur_lvl != {LW{1'b1}})); // R8

  AST_RSV_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> !((irq_num >= TW'(11)) && (irq_num <= TW'(15)))); // R9

endmodule

bind trap_dispatch trap_dispatch_checker #(.NF(NF), .TW(TW), .LW(LW), .WW(WW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .stk_valid (stk_valid_o),
  .stk_ready (stk_ready_i),
  .stk_data  (stk_data_o),
  .done      (done_o),
  .src       (src_o),
  .vec       (vec_o),
  .level     (level_o),
  .sw_ack    (sw_ack_o),
  .irq_ack   (irq_ack_o),
  .irq_num   (irq_num_i),
  .flags     (flags_o),
  .clr_we    (flag_clr_we_i),
  .hw_take   (hw_take),
  .cur_lvl   (cur_lvl)
);

// File: tb/trap_dispatch_bench.sv
module trap_dispatch_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [5:0]  fault = '0, cancel = '0, clr_data = '0;
  logic        commit = 1'b0, clr_we = 1'b0, sw_req = 1'b0, irq_req = 1'b0;
  logic [6:0]  sw_num = '0, irq_num = '0;
  logic [3:0]  irq_lvl = '0;
  logic [15:0] psw = '0, ip = '0;
  logic [7:0]  csp = '0;
  logic        seg_en = 1'b0, stk_ready = 1'b1;

  logic        stk_valid, sw_ack, irq_ack, busy, done, wb_en;
  logic [15:0] stk_data;
  logic [8:0]  vec;
  logic [3:0]  level;
  logic [7:0]  csp_out;
  logic [1:0]  src;
  logic [2:0]  cause;
  logic [5:0]  flags;

  trap_dispatch u_trap_dispatch (
    .clk(clk), .rst_n(rst_n), .fault_i(fault), .cancel_i(cancel), .commit_i(commit),
    .flag_clr_we_i(clr_we), .flag_clr_data_i(clr_data), .sw_req_i(sw_req), .sw_num_i(sw_num),
    .irq_req_i(irq_req), .irq_num_i(irq_num), .irq_lvl_i(irq_lvl), .psw_i(psw), .csp_i(csp),
    .ip_i(ip), .seg_en_i(seg_en), .stk_ready_i(stk_ready), .stk_valid_o(stk_valid),
    .stk_data_o(stk_data), .sw_ack_o(sw_ack), .irq_ack_o(irq_ack), .busy_o(busy), .done_o(done),
    .vec_o(vec), .level_o(level), .csp_o(csp_out), .src_o(src), .cause_o(cause),
    .flags_o(flags), .wb_en_o(wb_en)
  );

  int checks = 0;
  int errors = 0;
  int hw_seen = 0;
  bit finished = 0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Reference model state
  int          m_phase = 0;
  logic [15:0] m_q[$];
  int          m_vec = 0, m_lvl = 0, m_csp = 0, m_src = 0, m_cause = 0;
  int          m_flags = 0, m_arr = 0;

  function automatic int lowest_bit(input int v);
    for (int i = 0; i < 6; i++) if (v[i]) return i;
    return 0;
  endfunction

  function automatic int want_src();
    int lvl;
    lvl = int'(psw[15:12]);
    if (m_phase != 0) return 0;
    if (m_arr != 0 && lvl != 15) return 1;
    if (sw_req) return 2;
    if (irq_req && int'(irq_lvl) > lvl && !(irq_num >= 7'd11 && irq_num <= 7'd15)) return 3;
    return 0;
  endfunction

  always @(posedge clk) begin
    int s;
    if (!rst_n) begin
      m_phase = 0; m_flags = 0; m_arr = 0; m_q.delete();
    end else begin
      s = want_src();
      case (m_phase)
        0: if (s != 0) begin
          m_q.delete();
          m_q.push_back(psw);
          if (seg_en) m_q.push_back({8'h00, csp});
          m_q.push_back(ip);
          m_src = s;
          m_vec = (s == 1) ? 40 : ((s == 2) ? int'(sw_num) * 4 : int'(irq_num) * 4);
          m_lvl = (s == 1) ? 15 : ((s == 2) ? int'(psw[15:12]) : int'(irq_lvl));
          m_csp = seg_en ? 0 : int'(csp);
          if (s == 1) m_cause = lowest_bit(m_arr);
          m_phase = 1;
        end
        1: if (stk_ready) begin
          void'(m_q.pop_front());
          if (m_q.size() == 0) m_phase = 2;
        end
        default: m_phase = 0;
      endcase
      m_arr   = (s == 1) ? int'(fault) : (m_arr | int'(fault));
      m_flags = (m_flags & int'(clr_we ? clr_data : 6'h3f)) | int'(fault);
    end
  end

  always @(negedge clk) begin
    int s;
    string lr;
    if (rst_n && !finished) begin
      s = want_src();
      chk("R9", "irq_ack", irq_ack, s == 3);
      chk("R4", "sw_ack", sw_ack, s == 2);
      chk("R12", "busy", busy, m_phase != 0);
      chk("R2", "stk_valid", stk_valid, m_phase == 1);
      if (m_phase == 1) chk("R2", "stk_data", stk_data, m_q[0]);
      chk("R12", "done", done, m_phase == 2);
      if (m_phase == 2) begin
        lr = (m_src == 1) ? "R6" : ((m_src == 2) ? "R4" : "R9");
        chk("R1", "vec", vec, m_vec);
        chk("R7", "src", src, m_src);
        chk(lr, "level", level, m_lvl);
        chk("R3", "csp", csp_out, m_csp);
        if (m_src == 1) chk("R6", "cause", cause, m_cause);
      end
      if (done && src == 2'd1) hw_seen++;
      chk("R5", "flags", flags, m_flags);
      chk("R10", "wb_en", wb_en, commit && ((fault & cancel) == 0));
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_fault(input logic [5:0] f, input logic [5:0] c);
    fault = f; cancel = c; commit = 1'b1;
    step(1);
    fault = '0; cancel = '0; commit = 1'b0;
  endtask

  initial begin
    int base;
    step(3);
    @(negedge clk);
    chk("R12", "reset busy", busy, 0);
    chk("R2", "reset stk_valid", stk_valid, 0);
    chk("R5", "reset flags", flags, 0);
    chk("R12", "reset done", done, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    psw = 16'h3000; csp = 8'h5A; ip = 16'h1234; seg_en = 1'b1; stk_ready = 1'b1;
    step(2);

    // R1 R2 R3 R4: software traps at several numbers
    sw_req = 1'b1; sw_num = 7'h20; step(1); sw_req = 1'b0; step(8);
    sw_req = 1'b1; sw_num = 7'h00; step(1); sw_req = 1'b0; step(8);
    seg_en = 1'b0; ip = 16'hBEEF;
    sw_req = 1'b1; sw_num = 7'h7F; step(1); sw_req = 1'b0;
    for (int i = 0; i < 12; i++) begin stk_ready = i[0]; step(1); end
    stk_ready = 1'b1; seg_en = 1'b1; step(4);

    // R9: interrupt above level, reserved number, below level
    irq_req = 1'b1; irq_lvl = 4'd5; irq_num = 7'h30; step(1); irq_req = 1'b0; step(8);
    irq_req = 1'b1; irq_lvl = 4'd9; irq_num = 7'h0C; step(4); irq_req = 1'b0;
    irq_req = 1'b1; irq_lvl = 4'd2; irq_num = 7'h31; step(4); irq_req = 1'b0;
    irq_req = 1'b1; irq_lvl = 4'd9; irq_num = 7'h10; step(1); irq_req = 1'b0; step(8);

    // R6 R10: two faults together, one cancelling
    pulse_fault(6'b010100, 6'b000100); step(8);

    // R7: fault pending against software trap and a held interrupt
    base = hw_seen;
    pulse_fault(6'b100000, 6'b000000);
    sw_req = 1'b1; sw_num = 7'h40; irq_req = 1'b1; irq_lvl = 4'd9; irq_num = 7'h22;
    step(1); sw_req = 1'b0; step(6); irq_req = 1'b0; step(8);
    @(negedge clk);
    chk("R7", "hw entry beat sw", hw_seen - base, 1);
    @(posedge clk); #1;

    // R8: maximum level blocks class B entry
    base = hw_seen;
    psw = 16'hF000; pulse_fault(6'b000001, 6'b000001); step(10);
    @(negedge clk);
    chk("R8", "entries while blocked", hw_seen - base, 0);
    @(posedge clk); #1;
    psw = 16'h2000; step(10);
    @(negedge clk);
    chk("R8", "entries after lowering", hw_seen - base, 1);
    @(posedge clk); #1;

    // R11: repeat fault while flag set and entry in progress
    base = hw_seen;
    pulse_fault(6'b000010, 6'b000000); step(2);
    pulse_fault(6'b000010, 6'b000000); step(16);
    @(negedge clk);
    chk("R11", "re-requested entries", hw_seen - base, 2);
    @(posedge clk); #1;

    // R5: write-zero clear, and clear racing a new fault
    clr_we = 1'b1; clr_data = 6'b111101; step(1); clr_we = 1'b0; step(2);
    clr_we = 1'b1; clr_data = 6'b000000; fault = 6'b001000; step(1);
    clr_we = 1'b0; fault = '0; step(10);
    clr_we = 1'b1; clr_data = 6'b000000; step(1); clr_we = 1'b0; step(3);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(10 * 20000);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule